// File: doc/BRIEF.md
# Direct-Mode Transmit Bit Interface

This block sits between an external controller and the transmit modulator when the radio is run without its packet engine. Bits arrive one at a time on one of two input pins and go straight to the modulator output. The block never queues them. The data input pins pass through a two-stage synchronizer. A selectable inversion sits between the synchronizer and the capture logic.

In paced (synchronous) mode, a programmable divider produces a square-wave bit clock at the programmed data rate. One bit is taken on each rising edge of that clock, so the controller can only send data as fast as the clock asks for it. A routing field places this clock on a general-purpose pin, on the interrupt pin, or on the serial data-out pin, or on none of them. The serial data-out pin may carry the clock only while the serial interface is deselected. In free-running (asynchronous) mode there is no bit clock and the divider setting has no effect. The selected input is then sampled on every system clock, and every transition is flagged with a one-cycle pulse.

A configuration check guards against Gaussian-shaped modulation being selected with no clock routed anywhere. While that check is raised, no bits are accepted.

Top module: `txd_direct_if`

## Requirements
- R1: While `rst_n` is low, and directly after it is released, `mod_data`, `mod_strobe`, `edge_pulse`, `gpio_o` and `irq_o` are 0.
- R2: In paced mode (`cfg_async`=0), let P be `cfg_div`, with values below 2 treated as 2. The bit clock has a period of P system cycles. It is low for floor(P/2) cycles and high for the remaining cycles.
- R3: In paced mode, `mod_strobe` pulses for exactly one cycle in the same cycle the bit clock goes high. In that cycle `mod_data` takes the selected synchronized input. Otherwise `mod_data` holds its value, so exactly one bit is accepted per period.
- R4: In free-running mode, the bit clock stays low and `mod_strobe` stays 0, whatever `cfg_div` holds. `mod_data` follows the selected input three system clocks after an input change: two synchronizer stages plus the output register.
- R5: In free-running mode, `edge_pulse` is high for one cycle, in the same cycle that `mod_data` changes value, and at no other time.
- R6: `cfg_route` selects where the bit clock appears. 2'b00 sends it nowhere. 2'b01 sends it to `gpio_o`. 2'b10 sends it to `sdo_o`. 2'b11 sends it to `irq_o`. A routing pin that is not selected drives 0.
- R7: With `cfg_route`=2'b10 and `cs_n` high, `sdo_o` carries the bit clock. Whenever `cs_n` is low, or the routing is anything else, `sdo_o` equals `sdo_spi`.
- R8: `cfg_src`=2'b01 selects `pin_b`. The values 2'b00, 2'b10 and 2'b11 select `pin_a`. The pin that is not selected has no effect on `mod_data`.
- R9: With `cfg_invert`=1, `mod_data` carries the complement of the selected input.
- R10: `cfg_err` is 1 exactly when `cfg_gfsk`=1 and `cfg_route`=2'b00. While it is set, `mod_strobe` stays 0 and `mod_data` holds its value in paced mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_async | input | 1 | 1 = free-running sampling, 0 = paced by bit clock |
| cfg_gfsk | input | 1 | 1 = Gaussian-shaped modulation selected |
| cfg_route | input | 2 | Bit clock routing: 00 none, 01 GPIO, 10 serial-out, 11 interrupt |
| cfg_src | input | 2 | Data input select: 01 pin_b, others pin_a |
| cfg_invert | input | 1 | Invert transmit data |
| cfg_div | input | 16 | Bit period in system cycles (minimum 2) |
| pin_a | input | 1 | Data input pin A (asynchronous) |
| pin_b | input | 1 | Data input pin B (asynchronous) |
| cs_n | input | 1 | Serial interface chip select, active low |
| sdo_spi | input | 1 | Serial interface's own data-out value |
| gpio_o | output | 1 | General-purpose pin clock output |
| sdo_o | output | 1 | Shared serial data-out pin |
| irq_o | output | 1 | Interrupt pin clock output |
| mod_data | output | 1 | Bit presented to the modulator |
| mod_strobe | output | 1 | One-cycle pulse when a paced bit is accepted |
| edge_pulse | output | 1 | One-cycle pulse on each free-running data transition |
| cfg_err | output | 1 | Gaussian modulation selected with no clock routed |

## Verification
Several behaviours are checked by assertions on every cycle. A strobe always coincides with a rising bit clock. No strobe occurs in free-running mode or while the configuration check is raised. `mod_data` never changes between strobes in paced mode. Edge pulses appear only in free-running mode. The bit clock stays low when pacing is off. The serial data-out pin belongs to the serial interface whenever chip select is low.

Other behaviours can only be shown by the bench's directed scenarios, which count cycles at the ports:
- the exact clock period and duty cycle for even, odd and undersized divide values;
- the three-cycle input latency;
- which bit value lands on the modulator;
- source selection and inversion;
- placement of the clock on each routing pin.

// File: rtl/txd_pkg.sv
package txd_pkg;

  typedef enum logic [1:0] {
    ROUTE_NONE = 2'b00,
    ROUTE_GPIO = 2'b01,
    ROUTE_SDO  = 2'b10,
    ROUTE_IRQ  = 2'b11
  } route_e;

  localparam logic [1:0] SRC_PIN_B = 2'b01;

  // Bit period in system cycles; anything below 2 is raised to 2.
  function automatic int unsigned eff_period(int unsigned div);
    return (div < 2) ? 2 : div;
  endfunction

  // Number of low cycles at the start of each bit period.
  function automatic int unsigned low_span(int unsigned div);
    return eff_period(div) >> 1;
  endfunction

  // Gaussian shaping needs a visible clock.
  function automatic logic bad_config(logic gfsk, logic [1:0] route);
    return gfsk && (route == ROUTE_NONE);
  endfunction

endpackage

// File: rtl/txd_in_sync.sv
module txd_in_sync #(
  parameter int NPIN  = 2,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pins,
  input  logic [1:0]      sel,
  input  logic            invert,
  output logic            data_s
);
  import txd_pkg::*;

  localparam int IDX_W = (NPIN > 1) ? $clog2(NPIN) : 1;

  logic [NPIN-1:0] synced;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], pins[p]};
    end
    assign synced[p] = chain[STAGES-1];
  end

  logic [IDX_W-1:0] pick;
  always_comb begin
    pick = '0;
    if (sel == SRC_PIN_B) pick = IDX_W'(1);
  end

  assign data_s = synced[pick] ^ invert;

endmodule

// File: rtl/txd_rate_gen.sv
module txd_rate_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             dclk,
  output logic             rise_evt
);
  import txd_pkg::*;

  logic [DIV_W-1:0] eff, half, cnt, cnt_nxt;
  logic             dclk_nxt;

  assign eff  = DIV_W'(eff_period(32'(div)));
  assign half = DIV_W'(low_span(32'(div)));

  always_comb begin
    if (!run)                           cnt_nxt = '0;
    else if (cnt >= eff - DIV_W'(1))    cnt_nxt = '0;
    else                                cnt_nxt = cnt + DIV_W'(1);
    dclk_nxt = run && (cnt_nxt >= half);
  end

  assign rise_evt = dclk_nxt && !dclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      dclk <= 1'b0;
    end else begin
      cnt  <= cnt_nxt;
      dclk <= dclk_nxt;
    end
  end

  // R4: with pacing off, the bit clock is held low.
  p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !dclk);

endmodule

// File: rtl/txd_clk_route.sv
module txd_clk_route (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] route,
  input  logic       dclk,
  input  logic       cs_n,
  input  logic       sdo_spi,
  output logic       gpio_o,
  output logic       sdo_o,
  output logic       irq_o
);
  import txd_pkg::*;

  route_e r;
  logic   sdo_take;

  assign r        = route_e'(route);
  assign sdo_take = (r == ROUTE_SDO) && cs_n;
  assign gpio_o   = (r == ROUTE_GPIO) && dclk;
  assign irq_o    = (r == ROUTE_IRQ) && dclk;
  assign sdo_o    = sdo_take ? dclk : sdo_spi;

  // R7: the serial interface owns its pin while selected.
  p_sdo_owned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (sdo_o == sdo_spi));

  // R6: at most one routing pin carries the clock.
  p_one_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gpio_o, irq_o, sdo_take && sdo_o}));

endmodule

// File: rtl/txd_direct_if.sv
module txd_direct_if #(
  parameter int DIV_W = 16,
  parameter int NPIN  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_async,
  input  logic             cfg_gfsk,
  input  logic [1:0]       cfg_route,
  input  logic [1:0]       cfg_src,
  input  logic             cfg_invert,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             pin_a,
  input  logic             pin_b,
  input  logic             cs_n,
  input  logic             sdo_spi,
  output logic             gpio_o,
  output logic             sdo_o,
  output logic             irq_o,
  output logic             mod_data,
  output logic             mod_strobe,
  output logic             edge_pulse,
  output logic             cfg_err
);
  import txd_pkg::*;

  logic [NPIN-1:0] pins;
  logic            data_s;
  logic            dclk;
  logic            rise_evt;
  logic            take_bit;

  always_comb begin
    pins    = '0;
    pins[0] = pin_a;
    pins[1] = pin_b;
  end

  assign cfg_err  = bad_config(cfg_gfsk, cfg_route);
  assign take_bit = !cfg_async && rise_evt && !cfg_err;

  txd_in_sync #(.NPIN(NPIN), .STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pins   (pins),
    .sel    (cfg_src),
    .invert (cfg_invert),
    .data_s (data_s)
  );

  txd_rate_gen #(.DIV_W(DIV_W)) u_rate (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (!cfg_async),
    .div      (cfg_div),
    .dclk     (dclk),
    .rise_evt (rise_evt)
  );

  txd_clk_route u_route (
    .clk     (clk),
    .rst_n   (rst_n),
    .route   (cfg_route),
    .dclk    (dclk),
    .cs_n    (cs_n),
    .sdo_spi (sdo_spi),
    .gpio_o  (gpio_o),
    .sdo_o   (sdo_o),
    .irq_o   (irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_data   <= 1'b0;
      mod_strobe <= 1'b0;
      edge_pulse <= 1'b0;
    end else begin
      mod_strobe <= 1'b0;
      edge_pulse <= 1'b0;
      if (cfg_async) begin
        mod_data   <= data_s;
        edge_pulse <= data_s ^ mod_data;
      end else if (take_bit) begin
        mod_data   <= data_s;
        mod_strobe <= 1'b1;
      end
    end
  end

  // R3: an accepted bit lines up with a rising bit clock.
  p_strobe_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mod_strobe |-> (dclk && !$past(dclk)));

  // R3: between strobes the paced output is frozen.
  p_hold_paced_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cfg_async) && !mod_strobe) |-> $stable(mod_data));

  // R4: no strobe in free-running mode.
  p_no_strobe_async_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mod_strobe |-> !$past(cfg_async));

  // R10: a bad configuration blocks acceptance.
  p_no_strobe_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mod_strobe |-> !$past(cfg_err));

  // R5: edge pulses only in free-running mode, and only with a data change.
  p_edge_async_r5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_pulse |-> ($past(cfg_async) && (mod_data != $past(mod_data))));

endmodule

// File: tb/txd_direct_if_bench.sv
`timescale 1ns/1ps
module txd_direct_if_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_async = 1'b0, cfg_gfsk = 1'b0, cfg_invert = 1'b0;
  logic [1:0]  cfg_route = 2'b01, cfg_src = 2'b00;
  logic [15:0] cfg_div = 16'd8;
  logic        pin_a = 1'b0, pin_b = 1'b0, cs_n = 1'b0, sdo_spi = 1'b0;
  logic        gpio_o, sdo_o, irq_o, mod_data, mod_strobe, edge_pulse, cfg_err;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  txd_direct_if u_txd_direct_if (
    .clk(clk), .rst_n(rst_n), .cfg_async(cfg_async), .cfg_gfsk(cfg_gfsk),
    .cfg_route(cfg_route), .cfg_src(cfg_src), .cfg_invert(cfg_invert),
    .cfg_div(cfg_div), .pin_a(pin_a), .pin_b(pin_b), .cs_n(cs_n),
    .sdo_spi(sdo_spi), .gpio_o(gpio_o), .sdo_o(sdo_o), .irq_o(irq_o),
    .mod_data(mod_data), .mod_strobe(mod_strobe), .edge_pulse(edge_pulse),
    .cfg_err(cfg_err)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int period_of(int d);
    return (d < 2) ? 2 : d;
  endfunction

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_strobe(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!mod_strobe && n < 200);
  endtask

  task automatic t_reset();
    step(2);
    chk(mod_data == 0 && mod_strobe == 0 && edge_pulse == 0, "R1 in reset outputs", mod_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(gpio_o == 0 && irq_o == 0 && mod_strobe == 0, "R1 after release", gpio_o, 0);
  endtask

  // R2/R3: clock period, duty, one bit per period
  task automatic t_paced(input int d, input logic check_data);
    int n, hi, p;
    logic [7:0] pat = 8'b1011_0010;
    cfg_async = 0; cfg_route = 2'b01; cfg_src = 2'b00; cfg_invert = 0; cfg_div = 16'(d);
    p = period_of(d);
    wait_strobe(n);
    for (int k = 0; k < 8; k++) begin
      if (check_data) pin_a = pat[k];
      hi = 0; n = 0;
      do begin @(negedge clk); n++; if (gpio_o) hi++; end while (!mod_strobe && n < 200);
      chk(n == p, $sformatf("R2 period div=%0d", d), n, p);
      chk(hi == p - p / 2, $sformatf("R2 high span div=%0d", d), hi, p - p / 2);
      chk(gpio_o == 1, "R3 strobe with rising clock", gpio_o, 1);
      if (check_data) chk(mod_data == pat[k], "R3 captured bit", mod_data, pat[k]);
    end
  endtask

  // R4/R5/R8/R9: free-running sampling
  task automatic t_async();
    logic prev;
    cfg_async = 1; cfg_route = 2'b01; cfg_src = 2'b00; cfg_invert = 0; cfg_div = 16'd5;
    step(6);
    for (int k = 0; k < 4; k++) begin
      prev = mod_data;
      pin_a = ~pin_a;
      if (k == 2) cfg_div = 16'd1234;
      step(2);
      chk(mod_data == prev && edge_pulse == 0, "R4 latency not early", mod_data, prev);
      step(1);
      chk(mod_data == pin_a, "R4 follows after three clocks", mod_data, pin_a);
      chk(edge_pulse == 1, "R5 edge pulse on change", edge_pulse, 1);
      step(1);
      chk(edge_pulse == 0 && mod_strobe == 0 && gpio_o == 0, "R5/R4 pulse width, no clock", edge_pulse, 0);
    end
    pin_a = 1; cfg_invert = 1; step(4);
    chk(mod_data == 0, "R9 inverted", mod_data, 0);
    cfg_invert = 0; cfg_src = 2'b01; pin_b = 1; pin_a = 0; step(4);
    chk(mod_data == 1, "R8 pin_b selected", mod_data, 1);
    pin_a = 1; n_edges_check();
    cfg_src = 2'b10; pin_a = 0; step(4);
    chk(mod_data == 0, "R8 code 10 selects pin_a", mod_data, 0);
  endtask

  task automatic n_edges_check();
    int e = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (edge_pulse) e++; end
    chk(e == 0 && mod_data == 1, "R8 unselected pin ignored", e, 0);
  endtask

  // R6/R7: routing
  task automatic t_route();
    int g, s, q, prev_s;
    cfg_async = 0; cfg_div = 16'd6; cfg_gfsk = 0;
    cfg_route = 2'b11; cs_n = 1; sdo_spi = 0; g = 0; q = 0; s = 0;
    for (int i = 0; i < 24; i++) begin @(negedge clk); g += gpio_o; q += irq_o; s += sdo_o; end
    chk(q == 12 && g == 0 && s == 0, "R6 clock on interrupt pin", q, 12);
    cfg_route = 2'b10; step(1); q = 0; s = 0; prev_s = sdo_o;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk); q += irq_o;
      if (sdo_o && !prev_s) s++;
      prev_s = sdo_o;
    end
    chk(s == 4 && q == 0, "R7 clock on serial-out while deselected", s, 4);
    cs_n = 0; sdo_spi = 1; s = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); s += sdo_o; end
    chk(s == 12, "R7 serial interface owns pin while selected", s, 12);
    cfg_route = 2'b00; cs_n = 1; sdo_spi = 0; g = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); g += gpio_o + irq_o + sdo_o; end
    chk(g == 0 && cfg_err == 0, "R6 route none drives nothing", g, 0);
  endtask

  // R10: bad configuration
  task automatic t_err();
    int n;
    logic held;
    cfg_async = 0; cfg_div = 16'd4; cfg_gfsk = 1; cfg_route = 2'b00; cfg_src = 2'b00;
    step(1);
    chk(cfg_err == 1, "R10 flag raised", cfg_err, 1);
    held = mod_data; n = 0;
    for (int i = 0; i < 30; i++) begin
      pin_a = ~pin_a; @(negedge clk); n += mod_strobe;
    end
    chk(n == 0 && mod_data == held, "R10 no strobe while flagged", n, 0);
    cfg_route = 2'b01; step(1);
    chk(cfg_err == 0, "R10 flag clears with routing", cfg_err, 0);
    wait_strobe(n);
    chk(mod_strobe == 1, "R10 strobes resume", mod_strobe, 1);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired before completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_paced(8, 1'b1);
    t_paced(3, 1'b1);
    t_paced(0, 1'b0);
    t_async();
    t_route();
    t_err();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule